// File: doc/BRIEF.md
# Vector Add-with-Carry Lane Engine

This engine works through a vector register group one element per clock. For every active element it adds or subtracts two source elements, or one source element and a sign-carrying scalar. It also adds the carry, or takes away the borrow, that it reads from a mask register. The results are written back into a destination register group. Elements between the vector length and the maximum element count are then cleared, one element per clock, so that the tail of the destination reads as zero.

The four register groups (first source, second source, mask, destination) are held inside the block as flat byte arrays. A byte-wide load port fills them and a combinational read port returns destination bytes. Element `i` of width `esz` bytes occupies bytes `i*esz` to `i*esz+esz-1`, least significant byte first. Mask bit `k` is bit `k%8` of mask byte `k/8`. The width code `sew` selects 1, 2, 4 or 8 byte elements for codes 0, 1, 2 and 3.

Top module: `vac_engine`

## Requirements
- R1: With `op_sub`=0, every destination element `i < vl` becomes (second source + first source + carry) modulo 2^(8*esz).
- R2: With `op_sub`=1, every destination element `i < vl` becomes (second source − first source − borrow) modulo 2^(8*esz).
- R3: The carry or borrow of element `i` is mask bit `i*mlen`; a position beyond the mask group reads as 0.
- R4: With `op_scalar`=1, the 64-bit `scalar` input is used in place of the first source, truncated to the low `8*esz` bits.
- R5: Destination bytes from `vl*esz` up to `vlmax*esz` are written with zero; bytes at and beyond `vlmax*esz` keep their value.
- R6: A start with `vl`=0 writes nothing, never raises `busy`, and pulses `done` in the cycle after the start edge.
- R7: `sew` codes 0, 1, 2, 3 give element widths of 1, 2, 4 and 8 bytes.
- R8: For `vl`>0, `busy` is high for exactly max(`vl`,`vlmax`) cycles beginning after the start edge, and `done` is high for one cycle directly after, with `busy` low.
- R9: A `start` sampled while `busy` is high is ignored: the running operation finishes with its own settings and its own length.
- R10: After reset, `busy` and `done` are low and every destination byte reads zero.
- R11: The load port writes `ld_data` at byte `ld_addr` of the group chosen by `ld_bank`: 0 first source, 1 second source, 2 mask, 3 destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Byte load strobe |
| ld_bank | input | 2 | Target group of the load |
| ld_addr | input | 5 | Byte address of the load |
| ld_data | input | 8 | Byte to load |
| rd_addr | input | 5 | Destination byte address to read |
| rd_data | output | 8 | Destination byte at `rd_addr` |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_sub | input | 1 | 0 add with carry, 1 subtract with borrow |
| op_scalar | input | 1 | 1 uses `scalar` as the first operand |
| sew | input | 2 | Element width code |
| vl | input | 6 | Active element count |
| vlmax | input | 6 | Element count of the group |
| mlen | input | 7 | Spacing of carry bits in the mask |
| scalar | input | 64 | Scalar operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Once the start edge has sampled the request, `busy` is high at the next sampling point and stays high for max(`vl`,`vlmax`) cycles. `done` is due at the sampling point after that and must be low again one cycle later. For `vl`=0, `done` is due at the first sampling point and `busy` never rises. The bench samples every cycle at the falling edge and compares `busy` and `done` with a count kept by its own model. It reads the destination back byte by byte only after `done`. The expected bytes come from the model's byte arrays, which it computes before it issues the start.

// File: rtl/vac_pkg.sv
package vac_pkg;

  typedef enum logic [1:0] {
    W8  = 2'd0,
    W16 = 2'd1,
    W32 = 2'd2,
    W64 = 2'd3
  } width_e;

  typedef struct packed {
    logic   sub;
    logic   scal;
    width_e width;
  } op_cfg_t;

  // keep-mask for one element of the given width
  function automatic logic [63:0] lane_mask(width_e w);
    case (w)
      W8:      return 64'h0000_0000_0000_00FF;
      W16:     return 64'h0000_0000_0000_FFFF;
      W32:     return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  // add-with-carry or subtract-with-borrow, wrapped to the element width
  function automatic logic [63:0] carry_arith(logic [63:0] a, logic [63:0] b,
                                              logic c, logic sub, width_e w);
    logic [63:0] r;
    r = sub ? (a - b - 64'(c)) : (a + b + 64'(c));
    return r & lane_mask(w);
  endfunction

endpackage

// File: rtl/vac_ctrl.sv
module vac_ctrl
  import vac_pkg::*;
#(
  parameter int CNTW   = 6,
  parameter int MLEN_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  op_cfg_t           cfg_i,
  input  logic [CNTW-1:0]   vl_i,
  input  logic [CNTW-1:0]   vlmax_i,
  input  logic [MLEN_W-1:0] mlen_i,
  input  logic [63:0]       scalar_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNTW-1:0]   idx_o,
  output logic              in_body_o,
  output op_cfg_t           cfg_o,
  output logic [MLEN_W-1:0] mlen_o,
  output logic [63:0]       scalar_o
);

  logic              busy_q, done_q;
  logic [CNTW-1:0]   idx_q, len_q, vl_q;
  op_cfg_t           cfg_q;
  logic [MLEN_W-1:0] mlen_q;
  logic [63:0]       scalar_q;

  logic accept, last_el;
  assign accept  = start && !busy_q;
  assign last_el = busy_q && (idx_q == len_q - CNTW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      idx_q    <= '0;
      len_q    <= '0;
      vl_q     <= '0;
      cfg_q    <= '0;
      mlen_q   <= '0;
      scalar_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        cfg_q    <= cfg_i;
        vl_q     <= vl_i;
        mlen_q   <= mlen_i;
        scalar_q <= scalar_i;
        idx_q    <= '0;
        len_q    <= (vlmax_i > vl_i) ? vlmax_i : vl_i;
        if (vl_i == '0) done_q <= 1'b1;
        else            busy_q <= 1'b1;
      end else if (busy_q) begin
        idx_q <= idx_q + CNTW'(1);
        if (last_el) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign idx_o     = idx_q;
  assign in_body_o = idx_q < vl_q;
  assign cfg_o     = cfg_q;
  assign mlen_o    = mlen_q;
  assign scalar_o  = scalar_q;

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start |=> $stable(cfg_q) && $stable(vl_q) && $stable(scalar_q) && $stable(mlen_q));

  a_r6_empty_run: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (vl_i == '0) |=> done_q && !busy_q);

  a_r8_finish: assert property (@(posedge clk) disable iff (!rst_n)
    last_el |=> !busy_q && done_q);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

endmodule

// File: rtl/vac_gather.sv
module vac_gather
  import vac_pkg::*;
#(
  parameter int NBYTES = 32,
  parameter int CNTW   = 6,
  parameter int MLEN_W = 7,
  parameter int OFFW   = 12
) (
  input  logic [NBYTES*8-1:0] src1_i,
  input  logic [NBYTES*8-1:0] src2_i,
  input  logic [NBYTES*8-1:0] mask_i,
  input  logic [CNTW-1:0]     idx_i,
  input  logic [MLEN_W-1:0]   mlen_i,
  input  logic [OFFW-1:0]     bitoff_i,
  input  logic                scal_i,
  input  logic [63:0]         scalar_i,
  output logic [63:0]         a_o,
  output logic [63:0]         b_o,
  output logic                cin_o
);

  localparam int NBITS = NBYTES * 8;
  localparam int WW    = NBITS + 64;
  localparam int POSW  = CNTW + MLEN_W;

  logic [WW-1:0]   src1_w, src2_w;
  logic [POSW-1:0] mpos;

  assign src1_w = {64'd0, src1_i};
  assign src2_w = {64'd0, src2_i};
  assign mpos   = POSW'(idx_i) * POSW'(mlen_i);

  // operands: low 64 bits at the element's bit offset
  assign a_o   = 64'(src2_w >> bitoff_i);
  assign b_o   = scal_i ? scalar_i : 64'(src1_w >> bitoff_i);
  // carry bit; shifting past the group yields zero
  assign cin_o = 1'(mask_i >> mpos);

endmodule

// File: rtl/vac_alu.sv
module vac_alu
  import vac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] a_i,
  input  logic [63:0] b_i,
  input  logic        cin_i,
  input  logic        sub_i,
  input  width_e      width_i,
  input  logic        in_body_i,
  input  logic        act_i,
  output logic [63:0] res_o
);

  assign res_o = in_body_i ? carry_arith(a_i, b_i, cin_i, sub_i, width_i) : 64'd0;

  // inverse relations: undo the operation and expect zero in the lane
  a_r1_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
    act_i && in_body_i && !sub_i |->
      (((res_o - a_i - b_i - 64'(cin_i)) & lane_mask(width_i)) == 64'd0));

  a_r2_sub_diff: assert property (@(posedge clk) disable iff (!rst_n)
    act_i && in_body_i && sub_i |->
      (((res_o + b_i + 64'(cin_i) - a_i) & lane_mask(width_i)) == 64'd0));

endmodule

// File: rtl/vac_engine.sv
module vac_engine
  import vac_pkg::*;
#(
  parameter int NBYTES = 32,
  parameter int MLEN_W = 7,
  localparam int AW    = $clog2(NBYTES),
  localparam int CNTW  = $clog2(NBYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [1:0]        ld_bank,
  input  logic [AW-1:0]     ld_addr,
  input  logic [7:0]        ld_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [7:0]        rd_data,
  input  logic              start,
  input  logic              op_sub,
  input  logic              op_scalar,
  input  logic [1:0]        sew,
  input  logic [CNTW-1:0]   vl,
  input  logic [CNTW-1:0]   vlmax,
  input  logic [MLEN_W-1:0] mlen,
  input  logic [63:0]       scalar,
  output logic              busy,
  output logic              done
);

  localparam int NBITS = NBYTES * 8;
  localparam int WW    = NBITS + 64;
  localparam int OFFW  = CNTW + 6;
  localparam int NSRC  = 3;

  // ---------------- storage ----------------
  logic [NBITS-1:0] src_q [NSRC];
  logic [NBITS-1:0] dst_q;
  logic [NBITS-1:0] ld_be, ld_dat;

  assign ld_be  = {{(NBITS-8){1'b0}}, 8'hFF}   << {ld_addr, 3'b000};
  assign ld_dat = {{(NBITS-8){1'b0}}, ld_data} << {ld_addr, 3'b000};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic [NBITS-1:0] bank_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank_q <= '0;
      else if (ld_en && (ld_bank == 2'(g)))
        bank_q <= (bank_q & ~ld_be) | (ld_dat & ld_be);
    end
    assign src_q[g] = bank_q;
  end

  // ---------------- control ----------------
  op_cfg_t           cfg_in, cfg_q;
  logic [CNTW-1:0]   idx;
  logic              in_body;
  logic [MLEN_W-1:0] mlen_q;
  logic [63:0]       scalar_q;

  assign cfg_in = '{sub: op_sub, scal: op_scalar, width: width_e'(sew)};

  vac_ctrl #(.CNTW(CNTW), .MLEN_W(MLEN_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cfg_i    (cfg_in),
    .vl_i     (vl),
    .vlmax_i  (vlmax),
    .mlen_i   (mlen),
    .scalar_i (scalar),
    .busy_o   (busy),
    .done_o   (done),
    .idx_o    (idx),
    .in_body_o(in_body),
    .cfg_o    (cfg_q),
    .mlen_o   (mlen_q),
    .scalar_o (scalar_q)
  );

  // bit offset of the current element: idx * esz * 8
  logic [OFFW-1:0] bitoff;
  assign bitoff = OFFW'(idx) << (32'(cfg_q.width) + 3);

  // ---------------- datapath ----------------
  logic [63:0] op_a, op_b, res;
  logic        cin;

  vac_gather #(.NBYTES(NBYTES), .CNTW(CNTW), .MLEN_W(MLEN_W), .OFFW(OFFW)) u_gather (
    .src1_i  (src_q[0]),
    .src2_i  (src_q[1]),
    .mask_i  (src_q[2]),
    .idx_i   (idx),
    .mlen_i  (mlen_q),
    .bitoff_i(bitoff),
    .scal_i  (cfg_q.scal),
    .scalar_i(scalar_q),
    .a_o     (op_a),
    .b_o     (op_b),
    .cin_o   (cin)
  );

  vac_alu u_alu (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_i      (op_a),
    .b_i      (op_b),
    .cin_i    (cin),
    .sub_i    (cfg_q.sub),
    .width_i  (cfg_q.width),
    .in_body_i(in_body),
    .act_i    (busy),
    .res_o    (res)
  );

  // ---------------- destination write ----------------
  logic [NBITS-1:0] el_be, el_dat, dst_after_ld, dst_d;
  assign el_be  = NBITS'({{NBITS{1'b0}}, lane_mask(cfg_q.width)} << bitoff);
  assign el_dat = NBITS'({{NBITS{1'b0}}, res} << bitoff);

  always_comb begin
    dst_after_ld = dst_q;
    if (ld_en && (ld_bank == 2'd3))
      dst_after_ld = (dst_q & ~ld_be) | (ld_dat & ld_be);
    dst_d = dst_after_ld;
    if (busy)
      dst_d = (dst_after_ld & ~el_be) | (el_dat & el_be);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dst_q <= '0;
    else        dst_q <= dst_d;
  end

  assign rd_data = 8'(dst_q >> {rd_addr, 3'b000});

  // ---------------- checking hooks ----------------
  logic            tail_wr_q;
  logic [OFFW-1:0] tail_off_q;
  logic [7:0]      tail_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_wr_q  <= 1'b0;
      tail_off_q <= '0;
    end else begin
      tail_wr_q  <= busy && !in_body;
      tail_off_q <= bitoff;
    end
  end

  assign tail_byte = 8'(dst_q >> tail_off_q);

  a_r5_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tail_wr_q && !(ld_en && ld_bank == 2'd3) |-> (tail_byte == 8'h00));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !(ld_en && ld_bank == 2'd3) |=> $stable(dst_q));

endmodule

// File: tb/sim_vac_engine.sv
module sim_vac_engine;

  localparam int NB = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_bank = '0;
  logic [4:0]  ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        start = 1'b0;
  logic        op_sub = 1'b0;
  logic        op_scalar = 1'b0;
  logic [1:0]  sew = '0;
  logic [5:0]  vl = '0;
  logic [5:0]  vlmax = '0;
  logic [6:0]  mlen = '0;
  logic [63:0] scalar = '0;
  logic        busy, done;

  always #10 clk = ~clk;

  vac_engine u0 (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_bank(ld_bank), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .start(start), .op_sub(op_sub), .op_scalar(op_scalar), .sew(sew),
    .vl(vl), .vlmax(vlmax), .mlen(mlen), .scalar(scalar),
    .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [4][NB];   // 0 src1, 1 src2, 2 mask, 3 expected destination

  task automatic chk(bit ok, string req, string what, longint unsigned act, longint unsigned expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic load_all();
    @(negedge clk);
    for (int bk = 0; bk < 4; bk++) begin
      for (int a = 0; a < NB; a++) begin
        logic [7:0] v;
        v = 8'($urandom);
        mem[bk][a] = v;
        ld_en = 1'b1; ld_bank = 2'(bk); ld_addr = 5'(a); ld_data = v;
        @(negedge clk);
      end
    end
    ld_en = 1'b0;
  endtask

  task automatic model(bit sb, bit sc, int w, int n, int nmax, int ml, longint unsigned s);
    int esz;
    esz = 1 << w;
    if (n == 0) return;
    for (int i = 0; i < n; i++) begin
      longint unsigned a, b, c, r;
      int bp;
      a = 0; b = 0;
      for (int k = 0; k < esz; k++) begin
        a |= longint'(mem[1][i*esz+k]) << (8*k);
        b |= longint'(mem[0][i*esz+k]) << (8*k);
      end
      if (sc) b = s;
      bp = i * ml;
      c = (bp < NB*8) ? longint'((mem[2][bp/8] >> (bp%8)) & 8'd1) : 0;
      r = sb ? (a - b - c) : (a + b + c);
      for (int k = 0; k < esz; k++) mem[3][i*esz+k] = 8'(r >> (8*k));
    end
    for (int i = n; i < nmax; i++)
      for (int k = 0; k < esz; k++) mem[3][i*esz+k] = 8'h00;
  endtask

  task automatic run(bit sb, bit sc, int w, int n, int nmax, int ml,
                     longint unsigned s, bit poke, string req);
    int len;
    model(sb, sc, w, n, nmax, ml, s);
    len = (nmax > n) ? nmax : n;
    @(negedge clk);
    start = 1'b1; op_sub = sb; op_scalar = sc; sew = 2'(w);
    vl = 6'(n); vlmax = 6'(nmax); mlen = 7'(ml); scalar = s;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      chk(done == 1'b1, "R6", "done after empty start", 64'(done), 1);
      chk(busy == 1'b0, "R6", "busy after empty start", 64'(busy), 0);
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R6", "quiet after empty pulse", 64'({busy, done}), 0);
    end else begin
      for (int k = 0; k < len; k++) begin
        chk(busy == 1'b1, "R8", "busy during run", 64'(busy), 1);
        chk(done == 1'b0, "R8", "done during run", 64'(done), 0);
        if (poke && k == 0) begin
          // R9: competing request with different settings
          start = 1'b1; op_sub = ~sb; op_scalar = 1'b1; sew = 2'd0;
          vl = 6'd1; vlmax = 6'd1; scalar = 64'hFF;
        end
        if (poke && k == 1) start = 1'b0;
        @(negedge clk);
      end
      chk(done == 1'b1, "R8", "done pulse", 64'(done), 1);
      chk(busy == 1'b0, "R8", "busy after last element", 64'(busy), 0);
      @(negedge clk);
      chk(done == 1'b0, "R8", "done one cycle", 64'(done), 0);
    end
    for (int a = 0; a < NB; a++) begin
      rd_addr = 5'(a);
      #1;
      chk(rd_data == mem[3][a], req, $sformatf("dest byte %0d", a), 64'(rd_data), 64'(mem[3][a]));
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(busy == 1'b0, "R10", "busy after reset", 64'(busy), 0);
    chk(done == 1'b0, "R10", "done after reset", 64'(done), 0);
    for (int a = 0; a < NB; a++) begin
      rd_addr = 5'(a);
      #1;
      chk(rd_data == 8'h00, "R10", "dest byte after reset", 64'(rd_data), 0);
    end
    // R11 checked through the destination readback of every run below
    load_all();
    run(1'b0, 1'b0, 0, 10, 16, 1, 64'd0, 1'b0, "R1 R3 R5 R7 R11");
    load_all();
    run(1'b1, 1'b0, 1, 5, 8, 2, 64'd0, 1'b0, "R2 R3 R5 R7");
    load_all();
    run(1'b0, 1'b1, 2, 3, 6, 4, 64'hFFFF_FFFF_FFFF_FFFB, 1'b0, "R4 R1 R5");
    load_all();
    run(1'b1, 1'b1, 3, 2, 4, 8, 64'h8000_0000_0000_0001, 1'b0, "R4 R2 R7");
    load_all();
    run(1'b0, 1'b1, 0, 7, 32, 3, 64'h0000_0000_0000_0180, 1'b0, "R4 R3 R5");
    load_all();
    run(1'b0, 1'b0, 3, 4, 4, 16, 64'd0, 1'b0, "R1 R3 R7");
    load_all();
    run(1'b1, 1'b0, 0, 32, 32, 9, 64'd0, 1'b0, "R2 R3");
    load_all();
    run(1'b0, 1'b0, 1, 0, 8, 1, 64'd0, 1'b0, "R6");
    load_all();
    run(1'b1, 1'b0, 2, 4, 8, 1, 64'd0, 1'b1, "R9 R2 R5");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule